// File: doc/BRIEF.md
# Outstanding Load Miss Tracker

This block lets a core keep several load misses in flight to external memory at the same time. A load miss request carries an address, a destination tag and two page attribute bits: C (cacheable) and B (bufferable). When the request is accepted, the tracker claims a free tracking slot, stores the tag there and issues a read on a request/response bus. The read carries the slot number as its ID.

Responses may come back in any order. Each response names a slot by its ID. On a matching response the tracker frees the slot and presents the returned data together with the stored destination tag on its completion outputs one cycle later.

Concurrency depends on the page attributes. Up to four loads may be outstanding. A strictly ordered access (C=0, B=0) is only admitted when nothing else is in flight. While such an access is outstanding, nothing else is admitted. Backpressure from the read bus and a shortage of slots both show up as a low request-ready output.

Top module: `ldt_tracker`

## Requirements
- R1: After reset, no slot is in use. `req_ready` is 1 when `rd_ready` is 1, and `done_valid` and `rsp_err` are 0.
- R2: An accepted request takes the free slot with the lowest index. `rd_valid` is high in the same cycle, `rd_id` carries that slot index (2 bits, slot 0 = 2'b00) and `rd_addr` equals `req_addr`.
- R3: Up to four slots may be in use at once. With all four in use, `req_ready` and `rd_valid` are 0.
- R4: A request with `req_cacheable`=0 and `req_bufferable`=0 is not accepted (`req_ready`=0) while any slot is in use.
- R5: While a load with `req_cacheable`=0 and `req_bufferable`=0 is outstanding, no request of any attribute is accepted.
- R6: Requests with `req_cacheable`=1 or `req_bufferable`=1 may occupy several slots at the same time, in any mix.
- R7: A response with `rsp_valid`=1 whose `rsp_id` names a slot in use gives `done_valid`=1 in the next cycle. In that cycle `done_tag` is the tag stored for that slot and `done_data` is `rsp_data`. Responses may arrive in any slot order.
- R8: A slot is released at the clock edge that takes its response. It is not offered to a request in that same cycle, and it can be allocated in the following cycle.
- R9: A response whose `rsp_id` names a slot not in use gives `rsp_err`=1 and `done_valid`=0 in the next cycle, and leaves every slot unchanged.
- R10: With `rd_ready`=0, `req_ready` is 0 and no slot is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load miss request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | ADDR_W | Load address |
| req_tag | input | TAG_W | Destination tag |
| req_cacheable | input | 1 | Page attribute C |
| req_bufferable | input | 1 | Page attribute B |
| rd_valid | output | 1 | Read issued to memory |
| rd_ready | input | 1 | Memory bus can take a read |
| rd_addr | output | ADDR_W | Read address |
| rd_id | output | ID_W | Slot number carried by the read |
| rsp_valid | input | 1 | Read response present |
| rsp_id | input | ID_W | Slot number of the response |
| rsp_data | input | DATA_W | Returned data |
| done_valid | output | 1 | Completed load |
| done_tag | output | TAG_W | Destination tag of completed load |
| done_data | output | DATA_W | Data of completed load |
| rsp_err | output | 1 | Response named an idle slot |

## Verification
The bench builds the tracker with its defaults: four slots, 32-bit address and data, and a 5-bit tag. Four slots keep the slot space small enough to sweep every ordered pair of the four attribute kinds from an empty tracker, and to fill the tracker completely. The sweep exercises every admission decision of the single-outstanding rule. With a full tracker, the bench also drains the slots out of order, runs a release and a request in the same cycle, sends a response to an idle slot and applies bus backpressure. A scoreboard in the bench works out each expected slot index and tag from the requirements.

// File: rtl/ldt_pkg.sv
package ldt_pkg;

  // Page kind as {C, B}
  typedef enum logic [1:0] {
    PG_STRICT    = 2'b00,
    PG_BUF       = 2'b01,
    PG_CACHE     = 2'b10,
    PG_CACHE_BUF = 2'b11
  } page_kind_e;

  function automatic logic is_strict(input logic c, input logic b);
    return (page_kind_e'({c, b}) == PG_STRICT);
  endfunction

endpackage

// File: rtl/ldt_alloc.sv
// Lowest-index free slot finder
module ldt_alloc #(
  parameter int NUM_SLOTS = 4,
  localparam int ID_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] busy,
  output logic                 any_free,
  output logic                 any_busy,
  output logic [ID_W-1:0]      free_idx
);

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        free_idx = ID_W'(i);
      end
    end
  end

  assign any_busy = |busy;

endmodule

// File: rtl/ldt_admit.sv
// Admission policy: slot availability, ordering rule, bus backpressure
module ldt_admit (
  input  logic req_strict,
  input  logic any_free,
  input  logic any_busy,
  input  logic strict_active,
  input  logic bus_ready,
  output logic can_issue,
  output logic ready
);

  logic order_ok;

  always_comb begin
    order_ok  = !strict_active && !(req_strict && any_busy);
    can_issue = any_free && order_ok;
    ready     = can_issue && bus_ready;
  end

endmodule

// File: rtl/ldt_slot_table.sv
// Per-slot occupancy, tag and ordering flag
module ldt_slot_table #(
  parameter int NUM_SLOTS = 4,
  parameter int TAG_W     = 5,
  localparam int ID_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic [ID_W-1:0]      alloc_idx,
  input  logic [TAG_W-1:0]     alloc_tag,
  input  logic                 alloc_strict,
  input  logic                 free_en,
  input  logic [ID_W-1:0]      free_idx,
  input  logic [ID_W-1:0]      look_idx,
  output logic [NUM_SLOTS-1:0] busy,
  output logic                 strict_active,
  output logic [TAG_W-1:0]     look_tag
);

  logic [NUM_SLOTS-1:0] busy_q;
  logic [NUM_SLOTS-1:0] strict_q;
  logic [TAG_W-1:0]     tag_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic set_s;
    logic clr_s;
    logic busy_d;
    logic strict_d;

    always_comb begin
      set_s    = alloc_en && (alloc_idx == ID_W'(s));
      clr_s    = free_en  && (free_idx  == ID_W'(s));
      busy_d   = busy_q[s];
      strict_d = strict_q[s];
      if (clr_s) begin
        busy_d   = 1'b0;
        strict_d = 1'b0;
      end
      if (set_s) begin
        busy_d   = 1'b1;
        strict_d = alloc_strict;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[s]   <= 1'b0;
        strict_q[s] <= 1'b0;
      end else begin
        busy_q[s]   <= busy_d;
        strict_q[s] <= strict_d;
      end
    end

    always_ff @(posedge clk) begin
      if (set_s) begin
        tag_q[s] <= alloc_tag;
      end
    end
  end

  assign busy          = busy_q;
  assign strict_active = |(busy_q & strict_q);
  assign look_tag      = tag_q[look_idx];

endmodule

// File: rtl/ldt_rsp.sv
// Response matching and completion outputs
module ldt_rsp #(
  parameter int NUM_SLOTS = 4,
  parameter int TAG_W     = 5,
  parameter int DATA_W    = 32,
  localparam int ID_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rsp_valid,
  input  logic [ID_W-1:0]      rsp_id,
  input  logic [DATA_W-1:0]    rsp_data,
  input  logic [NUM_SLOTS-1:0] busy,
  input  logic [TAG_W-1:0]     slot_tag,
  output logic                 free_en,
  output logic                 done_valid,
  output logic [TAG_W-1:0]     done_tag,
  output logic [DATA_W-1:0]    done_data,
  output logic                 rsp_err
);

  logic in_range;
  logic hit;
  logic miss;
  logic done_d;
  logic err_d;
  logic done_q;
  logic err_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    in_range = (int'(rsp_id) < NUM_SLOTS);
    hit      = rsp_valid && in_range && busy[rsp_id];
    miss     = rsp_valid && !hit;
    done_d   = hit;
    err_d    = miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hit) begin
      tag_q  <= slot_tag;
      data_q <= rsp_data;
    end
  end

  assign free_en    = hit;
  assign done_valid = done_q;
  assign done_tag   = tag_q;
  assign done_data  = data_q;
  assign rsp_err    = err_q;

endmodule

// File: rtl/ldt_tracker.sv
module ldt_tracker #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 5,
  parameter int DATA_W    = 32,
  localparam int ID_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              req_cacheable,
  input  logic              req_bufferable,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ID_W-1:0]   rd_id,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic [DATA_W-1:0] done_data,
  output logic              rsp_err
);

  import ldt_pkg::*;

  logic [NUM_SLOTS-1:0] slot_busy;
  logic                 strict_active;
  logic                 any_free;
  logic                 any_busy;
  logic [ID_W-1:0]      free_idx;
  logic                 req_strict;
  logic                 can_issue;
  logic                 admit_ready;
  logic                 accept;
  logic                 rel_en;
  logic [TAG_W-1:0]     rel_tag;

  assign req_strict = is_strict(req_cacheable, req_bufferable);

  ldt_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
    .busy     (slot_busy),
    .any_free (any_free),
    .any_busy (any_busy),
    .free_idx (free_idx)
  );

  ldt_admit u_admit (
    .req_strict    (req_strict),
    .any_free      (any_free),
    .any_busy      (any_busy),
    .strict_active (strict_active),
    .bus_ready     (rd_ready),
    .can_issue     (can_issue),
    .ready         (admit_ready)
  );

  assign accept = req_valid && admit_ready;

  ldt_slot_table #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) u_table (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_en      (accept),
    .alloc_idx     (free_idx),
    .alloc_tag     (req_tag),
    .alloc_strict  (req_strict),
    .free_en       (rel_en),
    .free_idx      (rsp_id),
    .look_idx      (rsp_id),
    .busy          (slot_busy),
    .strict_active (strict_active),
    .look_tag      (rel_tag)
  );

  ldt_rsp #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_valid  (rsp_valid),
    .rsp_id     (rsp_id),
    .rsp_data   (rsp_data),
    .busy       (slot_busy),
    .slot_tag   (rel_tag),
    .free_en    (rel_en),
    .done_valid (done_valid),
    .done_tag   (done_tag),
    .done_data  (done_data),
    .rsp_err    (rsp_err)
  );

  assign req_ready = admit_ready;
  assign rd_valid  = req_valid && can_issue;
  assign rd_addr   = req_addr;
  assign rd_id     = free_idx;

endmodule

// File: rtl/ldt_chk.sv
module ldt_chk #(
  parameter int NUM_SLOTS = 4,
  localparam int ID_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_cacheable,
  input logic                 req_bufferable,
  input logic                 rd_ready,
  input logic                 rd_valid,
  input logic [ID_W-1:0]      rd_id,
  input logic                 rsp_valid,
  input logic [ID_W-1:0]      rsp_id,
  input logic                 done_valid,
  input logic                 rsp_err,
  input logic [NUM_SLOTS-1:0] busy,
  input logic                 strict_active
);

  logic [NUM_SLOTS-1:0] below;
  logic [ID_W-1:0]      rsp_id_q;
  logic                 hit_now;

  always_comb begin
    below   = (NUM_SLOTS'(1) << rd_id) - NUM_SLOTS'(1);
    hit_now = rsp_valid && busy[rsp_id];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_id_q <= '0;
    else        rsp_id_q <= rsp_id;
  end

  AST_ISSUE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (((busy & below) == below) && !busy[rd_id])); // R2

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> (!req_ready && !rd_valid)); // R3

  AST_STRICT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_cacheable && !req_bufferable) |-> (busy == '0)); // R4

  AST_STRICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    strict_active |-> !req_ready); // R5

  AST_ACCEPT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy[$past(rd_id)]); // R6

  AST_DONE_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> done_valid); // R7

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> !busy[rsp_id_q]); // R8

  AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !done_valid); // R9

  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !busy[rsp_id] && !(req_valid && req_ready)) |=> $stable(busy)); // R9

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |-> !req_ready); // R10

endmodule

bind ldt_tracker ldt_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_cacheable  (req_cacheable),
  .req_bufferable (req_bufferable),
  .rd_ready       (rd_ready),
  .rd_valid       (rd_valid),
  .rd_id          (rd_id),
  .rsp_valid      (rsp_valid),
  .rsp_id         (rsp_id),
  .done_valid     (done_valid),
  .rsp_err        (rsp_err),
  .busy           (slot_busy),
  .strict_active  (strict_active)
);

// File: tb/sim_ldt_tracker.sv
`timescale 1ns/1ps
module sim_ldt_tracker;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [4:0]  req_tag;
  logic        req_cacheable;
  logic        req_bufferable;
  logic        rd_valid;
  logic        rd_ready;
  logic [31:0] rd_addr;
  logic [1:0]  rd_id;
  logic        rsp_valid;
  logic [1:0]  rsp_id;
  logic [31:0] rsp_data;
  logic        done_valid;
  logic [4:0]  done_tag;
  logic [31:0] done_data;
  logic        rsp_err;

  int checks = 0;
  int fails  = 0;

  // scoreboard
  bit [3:0] mbusy;
  bit [3:0] mstrict;
  bit [4:0] mtag [4];

  ldt_tracker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_tag(req_tag), .req_cacheable(req_cacheable), .req_bufferable(req_bufferable),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_id(rd_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .done_valid(done_valid), .done_tag(done_tag), .done_data(done_data),
    .rsp_err(rsp_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // One cycle: optional request and optional response
  task automatic step(input bit dq, input bit [31:0] a, input bit [4:0] t,
                      input bit c, input bit b, input bit rdy,
                      input bit dr, input bit [1:0] id, input bit [31:0] d);
    bit       any_free;
    bit [1:0] low;
    bit       strict_req;
    bit       allowed;
    bit       exp_ready;
    bit       hit;
    bit [4:0] exp_tag;
    string    lbl;
    @(negedge clk);
    req_valid = dq; req_addr = a; req_tag = t;
    req_cacheable = c; req_bufferable = b; rd_ready = rdy;
    rsp_valid = dr; rsp_id = id; rsp_data = d;
    #1;
    any_free = (mbusy != 4'hF);
    low = 2'd0;
    for (int i = 3; i >= 0; i--) if (!mbusy[i]) low = 2'(i);
    strict_req = !c && !b;
    allowed = any_free && (mstrict == 4'h0) && (!strict_req || mbusy == 4'h0);
    exp_ready = allowed && rdy;
    if (!rdy)                              lbl = "R10";
    else if (!any_free)                    lbl = "R3";
    else if (mstrict != 4'h0)              lbl = "R5";
    else if (strict_req && mbusy != 4'h0)  lbl = "R4";
    else if (mbusy != 4'h0)                lbl = "R6";
    else                                   lbl = "R2";
    chk(req_ready == exp_ready, {lbl, " req_ready"}, req_ready, exp_ready);
    if (dq) begin
      chk(rd_valid == allowed, {lbl, " rd_valid"}, rd_valid, allowed);
      if (allowed) begin
        chk(rd_id == low, "R2/R8 rd_id lowest free", rd_id, low);
        chk(rd_addr == a, "R2 rd_addr", rd_addr, a);
      end
    end
    hit = dr && mbusy[id];
    exp_tag = mtag[id];
    @(posedge clk);
    #1;
    chk(done_valid == hit, "R7 done_valid", done_valid, hit);
    if (hit) begin
      chk(done_tag == exp_tag, "R7 done_tag", done_tag, exp_tag);
      chk(done_data == d, "R7 done_data", done_data, d);
    end
    chk(rsp_err == (dr && !hit), "R9 rsp_err", rsp_err, dr && !hit);
    if (hit) begin
      mbusy[id] = 1'b0;
      mstrict[id] = 1'b0;
    end
    if (dq && exp_ready) begin
      mbusy[low] = 1'b1;
      mstrict[low] = strict_req;
      mtag[low] = t;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic rsp(input bit [1:0] id);
    step(0, 0, 0, 0, 0, 1, 1, id, 32'hD000_0000 + 32'(id) * 32'h111);
  endtask

  task automatic rq(input bit [4:0] t, input bit [1:0] kind);
    step(1, 32'h8000_0000 + 32'(t) * 32'h40, t, kind[1], kind[0], 1, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mbusy = '0; mstrict = '0;
    for (int i = 0; i < 4; i++) mtag[i] = '0;
    rst_n = 1'b0;
    req_valid = 0; req_addr = 0; req_tag = 0; req_cacheable = 0; req_bufferable = 0;
    rd_ready = 1; rsp_valid = 0; rsp_id = 0; rsp_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(done_valid == 1'b0, "R1 done_valid", done_valid, 0);
    chk(rsp_err == 1'b0, "R1 rsp_err", rsp_err, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);

    // R4 R5 R6: every ordered pair of page kinds {C,B}
    for (int k1 = 0; k1 < 4; k1++) begin
      for (int k2 = 0; k2 < 4; k2++) begin
        rq(5'(k1 * 4 + k2), 2'(k1));
        rq(5'(k1 * 4 + k2 + 16), 2'(k2));
        for (int s = 3; s >= 0; s--) if (mbusy[s]) rsp(2'(s));
        idle();
      end
    end

    // R3 fill all four, fifth blocked
    for (int i = 0; i < 4; i++) rq(5'(20 + i), 2'b11);
    rq(5'd30, 2'b10);
    // R8 response to slot 2 with a request in the same cycle: still full
    step(1, 32'h9000_0000, 5'd31, 1, 0, 1, 1, 2'd2, 32'hCAFE_0002);
    // R8 slot 2 reused on the next cycle
    rq(5'd25, 2'b01);
    // R7 out-of-order drain
    rsp(2'd0); rsp(2'd3); rsp(2'd2); rsp(2'd1);
    idle();

    // R9 response to an idle slot while 0,1 busy
    rq(5'd7, 2'b10);
    rq(5'd8, 2'b10);
    rsp(2'd3);
    rq(5'd9, 2'b10);   // must still get slot 2
    rsp(2'd2); rsp(2'd1); rsp(2'd0);
    rsp(2'd0);         // R9 second idle response

    // R10 backpressure
    step(1, 32'h1234_0000, 5'd3, 1, 1, 0, 0, 0, 0);
    step(1, 32'h1234_0040, 5'd4, 0, 0, 0, 0, 0, 0);
    rq(5'd5, 2'b00);   // accepted afterwards into slot 0
    rsp(2'd0);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule